// File: doc/BRIEF.md
# Memory-Resident Script Sequencer

This block is a small control engine that runs a list of bus operations stored in memory. A one-cycle start pulse makes it fetch fixed-size operation records, beginning at a base address, and carry each one out through a bus master port with separate read and write channels. It can write a register, read a register, stall until an interrupt line goes high, loop back with a branch-if-not-equal on the most recent read value, and stop. No other control is needed after the start pulse.

Each operation record is 16 bytes long and sits at `BASE + index*16`. The word at offset 0 is the opcode, offset 4 holds an address or a branch target, offset 8 holds a data value or a compare value, and offset 12 is reserved and never fetched. The block drives its current operation index on an 8-bit program counter output, raises a halt output when it stops, and gives one event strobe per executed operation, with flag bits that classify the event.

Top module: `script_seq`

## Requirements
- R1: Fetching operation `i` issues exactly three reads, to `BASE+16*i+0`, `+4` and `+8`. The reserved word at `+12` is never read.
- R2: Opcode word values are 0 stop, 1 write, 2 read, 3 wait for interrupt and 4 branch-if-not-equal. Any other value behaves as stop.
- R3: A write operation gives a single-cycle `wr_en_o` pulse with `wr_addr_o` taken from the +4 word, `wr_data_o` taken from the +8 word, and `wr_be_o` equal to 4'b1111.
- R4: A read operation issues one read to the address in the +4 word. It stores the returned data as the last-read value.
- R5: A branch-if-not-equal moves to the operation index in the low 8 bits of the +4 word when the last-read value differs from the +8 word. It sets event flag bit 3. Otherwise it continues at index+1 with flag bit 3 clear.
- R6: A wait operation holds the index and gives no event while `irq_i` is low. Once `irq_i` is high, it gives an event with flag bit 1 set and continues at index+1.
- R7: A `go_i` pulse while idle or stopped starts execution at index 0 and clears `halt_o`. A `go_i` pulse during execution is ignored.
- R8: A stop operation raises `halt_o` and gives an event with flag bit 2 set. After that there is no bus activity until the next `go_i`.
- R9: Every executed operation gives exactly one single-cycle `ev_valid_o` strobe. Write and read events carry all flags clear, and at most one flag bit is set in any event.
- R10: A `go_i` pulse after a stop reruns the program from index 0 with the same results.
- R11: `pc_o` shows the index of the operation being processed. After a stop it holds the index of the stop operation.
- R12: Only one read is outstanding at a time. No read is issued before the previous read's `rd_valid_i` has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | One-cycle start pulse |
| irq_i | input | 1 | Interrupt level watched by the wait operation |
| rd_en_o | output | 1 | Read request strobe |
| rd_addr_o | output | 32 | Read address |
| rd_data_i | input | 32 | Read return data |
| rd_valid_i | input | 1 | Read return strobe |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Write data |
| wr_be_o | output | 4 | Write byte enables |
| halt_o | output | 1 | High once a stop operation has executed |
| pc_o | output | 8 | Current operation index |
| ev_valid_o | output | 1 | One strobe per executed operation |
| ev_flags_o | output | 4 | Event class: bit 1 wait exit, bit 2 stop, bit 3 branch taken |

## Verification
The bench runs a loop program that triggers an interrupt, waits for it, acknowledges it, bumps a counter, reads the counter back and branches until the counter reaches a limit. It sweeps that limit and the memory read latency.

- With a limit of one the branch is never taken. A design with an inverted compare would then loop forever or skip the loop.
- Slow memory exposes a fetch that issues before data returns, or that reads the reserved word.
- A stray start pulse mid-run catches a design that restarts at index 0 while busy, because that would inflate the event count.
- A restart after a stop and an undefined opcode check the stop path. The bus must stay silent after a stop, and `pc_o` must hold the stop index.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int WORD_W     = 32;
    localparam int OP_STRIDE  = 16;
    localparam int WORDS_USED = 3;
    localparam int FLAG_W     = 4;
    localparam int FLAG_WAIT  = 1;
    localparam int FLAG_STOP  = 2;
    localparam int FLAG_JUMP  = 3;

    typedef enum logic [2:0] {
        K_STOP  = 3'd0,
        K_WRITE = 3'd1,
        K_READ  = 3'd2,
        K_WAIT  = 3'd3,
        K_BNE   = 3'd4,
        K_BAD   = 3'd7
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic [WORD_W-1:0]   arg_a;
        logic [WORD_W-1:0]   arg_b;
    } seq_op_t;

    function automatic op_kind_e decode_kind(input logic [WORD_W-1:0] w);
        case (w)
            32'd0:   return K_STOP;
            32'd1:   return K_WRITE;
            32'd2:   return K_READ;
            32'd3:   return K_WAIT;
            32'd4:   return K_BNE;
            default: return K_BAD;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] word_addr(input logic [WORD_W-1:0] base,
                                                    input logic [WORD_W-1:0] idx,
                                                    input logic [1:0]        w);
        return base + (idx * OP_STRIDE) + {28'd0, w, 2'b00};
    endfunction

endpackage

// File: rtl/seq_fetch.sv
module seq_fetch
    import seq_pkg::*;
#(
    parameter int              PC_W = 8,
    parameter logic [31:0]     BASE = 32'h0000_0400
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [PC_W-1:0]     pc_i,
    output logic                rd_en_o,
    output logic [WORD_W-1:0]   rd_addr_o,
    input  logic                rd_valid_i,
    input  logic [WORD_W-1:0]   rd_data_i,
    output logic                done_o,
    output seq_op_t             op_o
);
    localparam logic [1:0] LAST_W = 2'(WORDS_USED - 1);

    typedef enum logic [1:0] {F_IDLE, F_ISSUE, F_WAIT} fst_e;

    fst_e              st_q;
    logic [1:0]        w_q;
    logic              done_q;
    logic [WORD_W-1:0] word_q [WORDS_USED];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= F_IDLE;
            w_q    <= '0;
            done_q <= 1'b0;
            for (int i = 0; i < WORDS_USED; i++) word_q[i] <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                F_IDLE: if (start_i) begin
                    st_q <= F_ISSUE;
                    w_q  <= '0;
                end
                F_ISSUE: st_q <= F_WAIT;
                F_WAIT: if (rd_valid_i) begin
                    word_q[w_q] <= rd_data_i;
                    if (w_q == LAST_W) begin
                        done_q <= 1'b1;
                        st_q   <= F_IDLE;
                    end else begin
                        w_q  <= w_q + 2'd1;
                        st_q <= F_ISSUE;
                    end
                end
                default: st_q <= F_IDLE;
            endcase
        end
    end

    assign rd_en_o   = (st_q == F_ISSUE);
    assign rd_addr_o = word_addr(BASE, WORD_W'(pc_i), w_q);
    assign done_o    = done_q;
    assign op_o.kind  = decode_kind(word_q[0]);
    assign op_o.arg_a = word_q[1];
    assign op_o.arg_b = word_q[2];

    // R1: reserved word of a record is never requested
    p_no_reserved_r1: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> (rd_addr_o[3:2] != 2'b11));

    // R12: a fetch read is followed by waiting, never by another request
    p_fetch_single_r12: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |=> !rd_en_o);

endmodule

// File: rtl/seq_branch.sv
module seq_branch
    import seq_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [WORD_W-1:0]   load_data_i,
    input  logic [WORD_W-1:0]   expect_i,
    input  logic [PC_W-1:0]     target_i,
    input  logic [PC_W-1:0]     pc_i,
    output logic                taken_o,
    output logic [PC_W-1:0]     next_pc_o
);
    logic [WORD_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst)         last_q <= '0;
        else if (load_i) last_q <= load_data_i;
    end

    assign taken_o   = (last_q != expect_i);
    assign next_pc_o = taken_o ? target_i : pc_i + 1'b1;

    // R4: value captured on a read return drives the next compare
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (taken_o == ($past(load_data_i) != expect_i)));

endmodule

// File: rtl/script_seq.sv
module script_seq
    import seq_pkg::*;
#(
    parameter int          PC_W = 8,
    parameter logic [31:0] BASE = 32'h0000_0400
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_i,
    input  logic          irq_i,
    output logic          rd_en_o,
    output logic [31:0]   rd_addr_o,
    input  logic [31:0]   rd_data_i,
    input  logic          rd_valid_i,
    output logic          wr_en_o,
    output logic [31:0]   wr_addr_o,
    output logic [31:0]   wr_data_o,
    output logic [3:0]    wr_be_o,
    output logic          halt_o,
    output logic [7:0]    pc_o,
    output logic          ev_valid_o,
    output logic [3:0]    ev_flags_o
);
    typedef enum logic [2:0] {
        T_IDLE, T_FETCH, T_EXEC, T_RDISS, T_RDWAIT, T_IRQWAIT, T_HALT
    } tst_e;

    tst_e              st_q;
    logic [PC_W-1:0]   pc_q;
    logic              halt_q, kick_q;
    logic              wr_en_q;
    logic [31:0]       wr_addr_q, wr_data_q;
    logic [3:0]        wr_be_q;
    logic              ev_valid_q;
    logic [FLAG_W-1:0] ev_flags_q;

    logic              f_rd_en, f_done;
    logic [31:0]       f_rd_addr;
    seq_op_t           op;
    logic              br_taken;
    logic [PC_W-1:0]   br_next;
    logic              rd_load;

    seq_fetch #(.PC_W(PC_W), .BASE(BASE)) i_fetch (
        .clk        (clk),
        .rst        (rst),
        .start_i    (kick_q),
        .pc_i       (pc_q),
        .rd_en_o    (f_rd_en),
        .rd_addr_o  (f_rd_addr),
        .rd_valid_i (rd_valid_i),
        .rd_data_i  (rd_data_i),
        .done_o     (f_done),
        .op_o       (op)
    );

    assign rd_load = (st_q == T_RDWAIT) && rd_valid_i;

    seq_branch #(.PC_W(PC_W)) i_branch (
        .clk         (clk),
        .rst         (rst),
        .load_i      (rd_load),
        .load_data_i (rd_data_i),
        .expect_i    (op.arg_b),
        .target_i    (op.arg_a[PC_W-1:0]),
        .pc_i        (pc_q),
        .taken_o     (br_taken),
        .next_pc_o   (br_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= T_IDLE;
            pc_q       <= '0;
            halt_q     <= 1'b0;
            kick_q     <= 1'b0;
            wr_en_q    <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
            wr_be_q    <= '0;
            ev_valid_q <= 1'b0;
            ev_flags_q <= '0;
        end else begin
            kick_q     <= 1'b0;
            wr_en_q    <= 1'b0;
            wr_be_q    <= '0;
            ev_valid_q <= 1'b0;
            ev_flags_q <= '0;
            case (st_q)
                T_IDLE, T_HALT: if (go_i) begin
                    pc_q   <= '0;
                    halt_q <= 1'b0;
                    kick_q <= 1'b1;
                    st_q   <= T_FETCH;
                end
                T_FETCH: if (f_done) st_q <= T_EXEC;
                T_EXEC: begin
                    case (op.kind)
                        K_WRITE: begin
                            wr_en_q    <= 1'b1;
                            wr_be_q    <= 4'hF;
                            wr_addr_q  <= op.arg_a;
                            wr_data_q  <= op.arg_b;
                            ev_valid_q <= 1'b1;
                            pc_q       <= pc_q + 1'b1;
                            kick_q     <= 1'b1;
                            st_q       <= T_FETCH;
                        end
                        K_READ: st_q <= T_RDISS;
                        K_WAIT: st_q <= T_IRQWAIT;
                        K_BNE: begin
                            ev_valid_q            <= 1'b1;
                            ev_flags_q[FLAG_JUMP] <= br_taken;
                            pc_q                  <= br_next;
                            kick_q                <= 1'b1;
                            st_q                  <= T_FETCH;
                        end
                        default: begin
                            halt_q                <= 1'b1;
                            ev_valid_q            <= 1'b1;
                            ev_flags_q[FLAG_STOP] <= 1'b1;
                            st_q                  <= T_HALT;
                        end
                    endcase
                end
                T_RDISS: st_q <= T_RDWAIT;
                T_RDWAIT: if (rd_valid_i) begin
                    ev_valid_q <= 1'b1;
                    pc_q       <= pc_q + 1'b1;
                    kick_q     <= 1'b1;
                    st_q       <= T_FETCH;
                end
                T_IRQWAIT: if (irq_i) begin
                    ev_valid_q            <= 1'b1;
                    ev_flags_q[FLAG_WAIT] <= 1'b1;
                    pc_q                  <= pc_q + 1'b1;
                    kick_q                <= 1'b1;
                    st_q                  <= T_FETCH;
                end
                default: st_q <= T_IDLE;
            endcase
        end
    end

    assign rd_en_o    = f_rd_en | (st_q == T_RDISS);
    assign rd_addr_o  = (st_q == T_RDISS) ? op.arg_a : f_rd_addr;
    assign wr_en_o    = wr_en_q;
    assign wr_addr_o  = wr_addr_q;
    assign wr_data_o  = wr_data_q;
    assign wr_be_o    = wr_be_q;
    assign halt_o     = halt_q;
    assign pc_o       = 8'(pc_q);
    assign ev_valid_o = ev_valid_q;
    assign ev_flags_o = ev_flags_q;

    // R3: write strobe lasts one cycle with all lanes enabled
    p_wr_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> !wr_en_o);
    p_wr_lanes_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_be_o == 4'hF));
    // R12: never two reads in consecutive cycles
    p_one_read_r12: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |=> !rd_en_o);
    // R6: stall while the interrupt line is low
    p_wait_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == T_IRQWAIT && !irq_i) |=> (!ev_valid_o && $stable(pc_o)));
    // R9: at most one class flag, flags only with a strobe
    p_flags_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ev_flags_o) && (ev_valid_o || ev_flags_o == '0));
    // R8: stopping comes with a flagged event, then silence
    p_halt_flag_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_o) |-> (ev_valid_o && ev_flags_o[FLAG_STOP]));
    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (halt_o && !go_i) |=> (!rd_en_o && !wr_en_o && !ev_valid_o));
    // R7: start pulse from rest resets the index
    p_go_start_r7: assert property (@(posedge clk) disable iff (rst)
        (go_i && (st_q == T_IDLE || st_q == T_HALT)) |=> (pc_o == 8'd0 && !halt_o));

endmodule

// File: tb/test_script_seq.sv
`timescale 1ns/1ps
module test_script_seq;
    localparam logic [31:0] BASE   = 32'h0000_0400;
    localparam logic [31:0] A_CNT  = 32'h0000_1000;
    localparam logic [31:0] A_BUMP = 32'h0000_1004;
    localparam logic [31:0] A_TRIG = 32'h0000_1008;
    localparam logic [31:0] A_ACK  = 32'h0000_100C;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, go, irq;
    logic rd_en, rd_valid, wr_en, halt, ev_valid;
    logic [31:0] rd_addr, rd_data, wr_addr, wr_data;
    logic [3:0] wr_be, ev_flags;
    logic [7:0] pc;

    script_seq i_script_seq (
        .clk(clk), .rst(rst), .go_i(go), .irq_i(irq),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data), .rd_valid_i(rd_valid),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_be_o(wr_be),
        .halt_o(halt), .pc_o(pc), .ev_valid_o(ev_valid), .ev_flags_o(ev_flags)
    );

    logic [31:0] prog [0:31];
    int checks = 0, errors = 0;
    int lat_cfg = 0;
    int cnt_reg = 0;
    int n_ev = 0, n_wait = 0, n_stop = 0, n_jump = 0, n_wr = 0, n_rd = 0;
    int bad_be = 0, rsv_rd = 0, bad_flags = 0;
    bit pend = 0;
    int pend_cnt = 0;
    logic [31:0] pend_addr = '0;
    int irq_cd = -1;
    bit finished = 0;

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (a >= BASE && a < BASE + 32'd128) return prog[(a - BASE) >> 2];
        if (a == A_CNT) return 32'(cnt_reg);
        return 32'hDEAD_BEEF;
    endfunction

    // memory, interrupt source and monitors, all at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            rd_valid = 1'b0; rd_data = '0; irq = 1'b0; pend = 0; irq_cd = -1;
        end else begin
            if (rd_valid) rd_valid = 1'b0;
            if (pend) begin
                if (pend_cnt == 0) begin
                    rd_valid = 1'b1; rd_data = mem_read(pend_addr); pend = 0;
                end else pend_cnt--;
            end
            if (rd_en) begin
                n_rd++;
                if (rd_addr >= BASE && rd_addr < BASE + 32'd128 && rd_addr[3:2] == 2'b11) rsv_rd++;
                pend = 1; pend_cnt = lat_cfg; pend_addr = rd_addr;
            end
            if (irq_cd > 0) irq_cd--;
            else if (irq_cd == 0) begin irq = 1'b1; irq_cd = -1; end
            if (wr_en) begin
                n_wr++;
                if (wr_be != 4'hF) bad_be++;
                if (wr_addr == A_BUMP) cnt_reg++;
                if (wr_addr == A_TRIG) irq_cd = lat_cfg + 2;
                if (wr_addr == A_ACK) irq = 1'b0;
            end
            if (ev_valid) begin
                n_ev++;
                if (ev_flags[1]) n_wait++;
                if (ev_flags[2]) n_stop++;
                if (ev_flags[3]) n_jump++;
                if (ev_flags[0] || $countones(ev_flags) > 1) bad_flags++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_op(input int i, input logic [31:0] o, input logic [31:0] a, input logic [31:0] b);
        prog[i*4] = o; prog[i*4+1] = a; prog[i*4+2] = b; prog[i*4+3] = 32'hBAD0_0000;
    endtask

    task automatic load_loop(input int k);
        for (int i = 0; i < 32; i++) prog[i] = 32'hFFFF_FFFF;
        put_op(0, 32'd1, A_TRIG, 32'd1);
        put_op(1, 32'd3, 32'd0, 32'd0);
        put_op(2, 32'd1, A_ACK, 32'd1);
        put_op(3, 32'd1, A_BUMP, 32'd0);
        put_op(4, 32'd2, A_CNT, 32'd0);
        put_op(5, 32'd4, 32'd0, 32'(k));
        put_op(6, 32'd0, 32'd0, 32'd0);
    endtask

    task automatic pulse_go();
        @(negedge clk); go = 1'b1;
        @(negedge clk); go = 1'b0;
    endtask

    // returns 1 if halt seen within the limit
    task automatic wait_halt(output bit seen, input bit stray);
        seen = 0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (stray && c == 10) go = 1'b1;
            else go = 1'b0;
            if (halt) begin seen = 1; break; end
        end
        go = 1'b0;
    endtask

    task automatic run_loop(input int k, input int lat, input bit stray);
        int e0, w0, s0, j0, wr0;
        bit seen;
        lat_cfg = lat; cnt_reg = 0;
        load_loop(k);
        e0 = n_ev; w0 = n_wait; s0 = n_stop; j0 = n_jump; wr0 = n_wr;
        pulse_go();
        wait_halt(seen, stray);
        chk(seen, "R8 halt reached", int'(seen), 1);
        repeat (2) @(negedge clk);
        chk(n_ev - e0 == 6*k + 1, stray ? "R7 stray go ignored / R9 event count" : "R9 event count",
            n_ev - e0, 6*k + 1);
        chk(n_wait - w0 == k, "R6 wait exits", n_wait - w0, k);
        chk(n_jump - j0 == k - 1, "R5 branches taken", n_jump - j0, k - 1);
        chk(n_stop - s0 == 1, "R8 stop events", n_stop - s0, 1);
        chk(n_wr - wr0 == 3*k, "R3 write count", n_wr - wr0, 3*k);
        chk(cnt_reg == k, "R4 counter read back", cnt_reg, k);
        chk(pc == 8'd6, "R11 pc after stop", int'(pc), 6);
    endtask

    initial begin
        bit seen;
        int r0, w0b, e0b;
        rst = 1'b1; go = 1'b0;
        for (int i = 0; i < 32; i++) prog[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!halt && pc == 8'd0 && !rd_en && !wr_en && !ev_valid, "R7 reset state",
            int'({halt, rd_en, wr_en, ev_valid}) + int'(pc), 0);

        for (int k = 1; k <= 4; k++)
            for (int lat = 0; lat <= 2; lat++)
                run_loop(k, lat, 1'b0);
        run_loop(3, 1, 1'b1);

        // silence after stop
        r0 = n_rd; w0b = n_wr; e0b = n_ev;
        repeat (30) @(negedge clk);
        chk(n_rd == r0 && n_wr == w0b && n_ev == e0b, "R8 quiet after stop",
            (n_rd - r0) + (n_wr - w0b) + (n_ev - e0b), 0);
        chk(halt && pc == 8'd6, "R11 pc held after stop", int'(pc), 6);

        // rerun from index 0 after stop
        run_loop(2, 0, 1'b0);
        chk(halt, "R10 rerun completes", int'(halt), 1);

        // undefined opcode acts as stop at index 0
        for (int i = 0; i < 32; i++) prog[i] = 32'd0;
        put_op(0, 32'd9, A_BUMP, 32'd0);
        e0b = n_ev; w0b = n_wr; r0 = n_stop;
        pulse_go();
        wait_halt(seen, 1'b0);
        repeat (2) @(negedge clk);
        chk(seen && n_ev - e0b == 1 && n_stop - r0 == 1, "R2 bad opcode stops", n_ev - e0b, 1);
        chk(n_wr == w0b && pc == 8'd0, "R2 bad opcode no write, pc 0", n_wr - w0b + int'(pc), 0);

        chk(bad_be == 0, "R3 byte enables", bad_be, 0);
        chk(rsv_rd == 0, "R1 reserved word reads", rsv_rd, 0);
        chk(bad_flags == 0, "R9 flag encoding", bad_flags, 0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule